// File: doc/BRIEF.md
# Dual-Area Pixel Cache

This block sits between a wide input FIFO and a convolution processing array. Every FIFO word carries four 16-bit pixels. The cache keeps eight pixel registers in two areas of four. Area0 holds entries 0 to 3 and Area1 holds entries 4 to 7. Each refill loads one whole area from one FIFO word. A consumer takes one pixel per cycle for the 3×3 stride-1 and 1×1 kernel modes, and two adjacent pixels per cycle for the 3×3 stride-2 mode.

The cache generates the FIFO read enable itself. When a read consumes the last entry of an area, a per-area finish flag rises. That flag requests the next FIFO word in the same cycle. One cycle later, a registered copy of the flag writes the word into the drained area. The other area still holds four pixels, so a two-pixel reader never has to wait for a refill. The flags can only rise after data has been read, so the controller primes the cache at start-up with two pulses of an initial read enable.

Top module: `pix_pair_cache`

## Requirements
- R1: After synchronous reset, both areas are empty, the read pointer is entry 0, `pix_vld_o` is 0, and `fifo_rd_o` is 0 while `init_rd_i` is 0.
- R2: `fifo_rd_o` is high in the same cycle as an `init_rd_i` pulse, and in the same cycle as any read that consumes entry 3 or entry 7.
- R3: Successive `init_rd_i` pulses after reset fill Area0 first, then Area1, and keep alternating. Lane k of a FIFO word (bits 16k+15 down to 16k) goes to entry 4a+k of area a.
- R4: The FIFO word is expected on `fifo_word_i` in the cycle after `fifo_rd_o`. It is written into the area at the end of that cycle, and it can be read from the cycle after that.
- R5: `mode_i` is encoded as follows. 2'b00 is 3×3 stride 1 and 2'b01 is 1×1; both deliver one pixel on `pix0_o`. 2'b10 is 3×3 stride 2; it delivers entry p on `pix0_o` and entry p+1 on `pix1_o`, where p is the read pointer.
- R6: A read happens when `rd_req_i` and `pix_vld_o` are both high. It advances the pointer by 1, or by 2 in mode 2'b10, wrapping from 7 to 0. A two-pixel read over entries 3/4 or 7/0 returns the entries in ascending circular order.
- R7: Consuming entry 3 (or entry 7) drains Area0 (or Area1), which is then refilled from the next FIFO word. A full area is never overwritten.
- R8: `pix_vld_o` is low whenever any requested entry lies in an area that is not filled. If `rd_req_i` is low or `pix_vld_o` is low, the pointer does not move and no FIFO read is issued.
- R9: Once both areas have been primed and the FIFO answers every read, `pix_vld_o` stays high for any sequence of one-pixel and two-pixel reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Kernel mode (00 3×3 s1, 01 1×1, 10 3×3 s2) |
| rd_req_i | input | 1 | Consumer requests pixels this cycle |
| init_rd_i | input | 1 | Controller priming read enable |
| fifo_word_i | input | 64 | FIFO word with four pixels, arriving one cycle after the read |
| fifo_rd_o | output | 1 | FIFO read enable |
| pix_vld_o | output | 1 | Requested pixels are present |
| pix0_o | output | 16 | Pixel at the read pointer |
| pix1_o | output | 16 | Pixel at the read pointer plus one (used in mode 10) |

## Verification
`fifo_rd_o` and `pix_vld_o` are combinational from the current state and the inputs, so they are compared in the same cycle in which the stimulus is applied. The pixel outputs follow the pointer, which moves at the end of a read cycle, so they are compared one cycle after a read. A primed area reports valid two cycles after its read enable: the data arrives in the first cycle and is written at the end of it. The bench models the FIFO by driving the next word one cycle after each read enable it observes. It samples every output 1 ns after the falling edge and applies no input at a rising edge.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

    typedef enum logic [1:0] {
        KM_K3S1 = 2'b00,
        KM_K1S1 = 2'b01,
        KM_K3S2 = 2'b10,
        KM_RSVD = 2'b11
    } kmode_e;

    localparam int AREAS = 2;

    typedef logic [AREAS-1:0] area_vec_t;

    // Read-side view produced each cycle by the pointer logic
    typedef struct packed {
        logic      vld;
        logic      accept;
        area_vec_t fin;
    } rd_view_t;

    function automatic logic wants_pair(kmode_e m);
        return m == KM_K3S2;
    endfunction

    function automatic int unsigned step_of(kmode_e m);
        return wants_pair(m) ? 2 : 1;
    endfunction

endpackage

// File: rtl/pcache_fill_ctl.sv
module pcache_fill_ctl
    import pcache_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      init_rd_i,
    input  area_vec_t fin_i,
    output logic      fifo_rd_o,
    output area_vec_t we_o
);
    logic      init_sel_q;
    area_vec_t req;
    area_vec_t we_q;

    always_comb begin
        req = fin_i;
        if (init_rd_i) begin
            req[init_sel_q] = 1'b1;
        end
    end

    assign fifo_rd_o = |req;
    assign we_o      = we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            init_sel_q <= 1'b0;
            we_q       <= '0;
        end else begin
            we_q <= req;
            if (init_rd_i) begin
                init_sel_q <= ~init_sel_q;
            end
        end
    end

    // A refill request always turns into a write in the following cycle
    p_req_to_write_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |=> (we_o != '0));

endmodule

// File: rtl/pcache_store.sv
module pcache_store
    import pcache_pkg::*;
#(
    parameter int PIX_W = 16,
    parameter int LANES = 4,
    localparam int DEPTH = AREAS * LANES,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES*PIX_W-1:0] word_i,
    input  area_vec_t              we_i,
    input  area_vec_t              fin_i,
    input  logic [PTR_W-1:0]       ptr0_i,
    input  logic [PTR_W-1:0]       ptr1_i,
    output area_vec_t              full_o,
    output logic [PIX_W-1:0]       pix0_o,
    output logic [PIX_W-1:0]       pix1_o
);
    logic [PIX_W-1:0] mem [DEPTH];
    area_vec_t        full_q;

    for (genvar a = 0; a < AREAS; a++) begin : g_area
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            always_ff @(posedge clk) begin
                if (we_i[a]) begin
                    mem[a*LANES+k] <= word_i[k*PIX_W +: PIX_W];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                full_q[a] <= 1'b0;
            end else if (we_i[a]) begin
                full_q[a] <= 1'b1;
            end else if (fin_i[a]) begin
                full_q[a] <= 1'b0;
            end
        end
    end

    assign full_o = full_q;
    assign pix0_o = mem[ptr0_i];
    assign pix1_o = mem[ptr1_i];

    // Pixels still waiting to be read are never overwritten
    p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
        (we_i & full_q) == '0);

endmodule

// File: rtl/pcache_read_ctl.sv
module pcache_read_ctl
    import pcache_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DEPTH = AREAS * LANES,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OFS_W = PTR_W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  kmode_e           mode_i,
    input  logic             rd_req_i,
    input  area_vec_t        full_i,
    output logic [PTR_W-1:0] ptr0_o,
    output logic [PTR_W-1:0] ptr1_o,
    output rd_view_t         view_o
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_p1;
    logic             area0, area1;
    logic             pair;
    rd_view_t         view;

    assign ptr_p1 = ptr_q + PTR_W'(1);
    assign area0  = ptr_q[PTR_W-1];
    assign area1  = ptr_p1[PTR_W-1];
    assign pair   = wants_pair(mode_i);

    always_comb begin
        view        = '0;
        view.vld    = full_i[area0] && (!pair || full_i[area1]);
        view.accept = rd_req_i && view.vld;
        if (view.accept) begin
            if (ptr_q[OFS_W-1:0] == {OFS_W{1'b1}}) begin
                view.fin[area0] = 1'b1;
            end
            if (pair && ptr_p1[OFS_W-1:0] == {OFS_W{1'b1}}) begin
                view.fin[area1] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (view.accept) begin
            ptr_q <= ptr_q + PTR_W'(step_of(mode_i));
        end
    end

    assign ptr0_o = ptr_q;
    assign ptr1_o = ptr_p1;
    assign view_o = view;

    // No read, no movement
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !(rd_req_i && view.vld) |=> $stable(ptr_q));

    // Two consumed entries can never both end an area
    p_single_drain_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(view.fin));

endmodule

// File: rtl/pix_pair_cache.sv
module pix_pair_cache
    import pcache_pkg::*;
#(
    parameter int PIX_W = 16,
    parameter int LANES = 4,
    localparam int DEPTH = AREAS * LANES,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             mode_i,
    input  logic                   rd_req_i,
    input  logic                   init_rd_i,
    input  logic [LANES*PIX_W-1:0] fifo_word_i,
    output logic                   fifo_rd_o,
    output logic                   pix_vld_o,
    output logic [PIX_W-1:0]       pix0_o,
    output logic [PIX_W-1:0]       pix1_o
);
    kmode_e           mode;
    area_vec_t        full;
    area_vec_t        we;
    rd_view_t         view;
    logic [PTR_W-1:0] ptr0, ptr1;

    assign mode = kmode_e'(mode_i);

    pcache_read_ctl #(.LANES(LANES)) u_read (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (mode),
        .rd_req_i (rd_req_i),
        .full_i   (full),
        .ptr0_o   (ptr0),
        .ptr1_o   (ptr1),
        .view_o   (view)
    );

    pcache_fill_ctl u_fill (
        .clk       (clk),
        .rst       (rst),
        .init_rd_i (init_rd_i),
        .fin_i     (view.fin),
        .fifo_rd_o (fifo_rd_o),
        .we_o      (we)
    );

    pcache_store #(.PIX_W(PIX_W), .LANES(LANES)) u_store (
        .clk    (clk),
        .rst    (rst),
        .word_i (fifo_word_i),
        .we_i   (we),
        .fin_i  (view.fin),
        .ptr0_i (ptr0),
        .ptr1_i (ptr1),
        .full_o (full),
        .pix0_o (pix0_o),
        .pix1_o (pix1_o)
    );

    assign pix_vld_o = view.vld;

    // Nothing is presented straight out of reset
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> !pix_vld_o);

    // A FIFO read lands as a filled area two cycles later
    p_fill_lands_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |=> ##1 (full != '0));

    // A drain is always paired with a FIFO request in the same cycle
    p_drain_reads_r2: assert property (@(posedge clk) disable iff (rst)
        (view.fin != '0) |-> fifo_rd_o);

endmodule

// File: tb/test_pix_pair_cache.sv
`timescale 1ns/100ps
module test_pix_pair_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        rd_req = 1'b0;
    logic        init_rd = 1'b0;
    logic [63:0] fifo_word = '0;
    logic        fifo_rd, pix_vld;
    logic [15:0] pix0, pix1;

    int  errors = 0;
    int  checks = 0;
    int  widx = 0;
    int  e = 0;
    bit  pend = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    pix_pair_cache i_pix_pair_cache (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .rd_req_i    (rd_req),
        .init_rd_i   (init_rd),
        .fifo_word_i (fifo_word),
        .fifo_rd_o   (fifo_rd),
        .pix_vld_o   (pix_vld),
        .pix0_o      (pix0),
        .pix1_o      (pix1)
    );

    // Stream rows: {mode[1:0], rd_req}
    localparam int NV = 28;
    localparam logic [2:0] VEC [NV] = '{
        3'b101, 3'b101, 3'b001, 3'b101, 3'b101, 3'b101, 3'b000,
        3'b011, 3'b101, 3'b101, 3'b100, 3'b001, 3'b001, 3'b101,
        3'b101, 3'b101, 3'b101, 3'b011, 3'b000, 3'b101, 3'b001,
        3'b101, 3'b101, 3'b101, 3'b011, 3'b101, 3'b101, 3'b101
    };

    function automatic logic [15:0] pval(int n);
        return 16'h0100 + 16'(n);
    endfunction

    function automatic logic [63:0] mkw(int w);
        logic [63:0] r;
        for (int k = 0; k < 4; k++) r[k*16 +: 16] = pval(4*w + k);
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Apply inputs at a falling edge; the FIFO answers one cycle after a read
    task automatic drive(logic [1:0] m, logic rq, logic ini);
        if (pend) begin
            fifo_word = mkw(widx);
            widx++;
            pend = 0;
        end
        mode = m; rd_req = rq; init_rd = ini;
        #1;
        pend = fifo_rd;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_req = 1'b0; init_rd = 1'b0; pend = 0; widx = 0; e = 0;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: empty after reset even with a request pending
        drive(2'b00, 1'b1, 1'b0);
        chk("R1 vld", pix_vld, 0);
        chk("R1 fifo_rd", fifo_rd, 0);
        tick();

        // R2/R3: two priming pulses
        drive(2'b00, 1'b0, 1'b1);
        chk("R2 init read", fifo_rd, 1);
        tick();
        drive(2'b00, 1'b0, 1'b1);
        chk("R2 init read second", fifo_rd, 1);
        chk("R4 not yet valid", pix_vld, 0);
        tick();
        drive(2'b00, 1'b0, 1'b0);
        chk("R4 valid after write", pix_vld, 1);
        chk("R3 lane0 to entry0", pix0, pval(0));
        tick();

        // Vector walk: R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            logic [1:0] m;
            logic rq, dual, exp_rd;
            m = VEC[i][2:1];
            rq = VEC[i][0];
            dual = (m == 2'b10);
            drive(m, rq, 1'b0);
            chk("R9 no stall", pix_vld, 1);
            chk("R5 R6 pix0 order", pix0, pval(e));
            if (dual) chk("R5 R6 pix1 order", pix1, pval(e + 1));
            exp_rd = rq && ((e % 4 == 3) || (dual && ((e + 1) % 4 == 3)));
            chk(rq ? "R7 drain read" : "R8 idle no read", fifo_rd, exp_rd);
            if (rq) e += dual ? 2 : 1;
            tick();
        end

        // R8: two-pixel request across an unfilled area
        do_reset();
        drive(2'b00, 1'b0, 1'b1);
        tick();
        drive(2'b00, 1'b0, 1'b0);
        tick();
        for (int j = 0; j < 3; j++) begin
            drive(2'b01, 1'b1, 1'b0);
            chk("R5 single pixel", pix0, pval(e));
            e++;
            tick();
        end
        drive(2'b10, 1'b1, 1'b0);
        chk("R8 straddle into empty area", pix_vld, 0);
        chk("R8 no read while invalid", fifo_rd, 0);
        tick();
        drive(2'b00, 1'b1, 1'b0);
        chk("R8 pointer held", pix0, pval(3));
        chk("R7 last entry of Area0 reads FIFO", fifo_rd, 1);
        tick();
        drive(2'b00, 1'b1, 1'b0);
        chk("R7 drained area invalid", pix_vld, 0);
        tick();

        done = 1;
        summary();
        $finish;
    end

endmodule